// File: doc/BRIEF.md
# Stack Call/Return Sequencer

This block carries out the stack and subroutine commands of a small 8-bit processor core whose program counter and stack pointer are 16 bits wide. Decode hands it a command code and operands: a call target, a table index, and the current program counter, stack pointer, status byte and register pair. It then works through a fixed schedule. It pushes or pops bytes through a single byte-wide synchronous memory port, computes the new program counter, stack pointer, status byte and register pair, and raises `done` in the last clock of the command.

Each command has an exact length in clocks. Every memory access takes one strobe cycle. The clocks left over are wait states, so the length of a command does not depend on its data. A return from interrupt also pulses `nmi_clr`, which clears the non-maskable-interrupt in-service flag held elsewhere in the core. The call table sits at `TBL_BASE` (default 0x0000). Each entry is two bytes, low byte first, at `TBL_BASE + index` and `TBL_BASE + index + 1`.

Top module: `stk_call_seq`

## Requirements
- R1: A `start` that is high at a rising edge while the block is idle begins a command. `done` is high for exactly one cycle: the Nth cycle after that edge. `cmd` codes and N are: 0 direct call 6, 1 table call 8, 2 return 6, 3 interrupt return 8, 4 push status 2, 5 pop status 4, 6 push pair 4, 7 pop pair 6, 8 pair-to-SP 8, 9 SP-to-pair 6.
- R2: A direct call writes byte [15:8] of `pc_in`+3 to SP−1 and byte [7:0] of `pc_in`+3 to SP−2. It sets `pc_out` to `call_target` and `sp_out` to SP−2.
- R3: A table call writes `pc_in`+1 in the same high/low order. It sets `pc_out[7:0]` from address `TBL_BASE`+`tbl_idx` and `pc_out[15:8]` from `TBL_BASE`+`tbl_idx`+1, both read after the two pushes. It sets `sp_out` to SP−2.
- R4: A return sets `pc_out` to {mem[SP+1], mem[SP]} and `sp_out` to SP+2.
- R5: An interrupt return loads `pc_out` as a return does, sets `psw_out` to mem[SP+2] and `sp_out` to SP+3. It raises `nmi_clr` in the `done` cycle only, and for no other command.
- R6: A status push writes `psw_in` to SP−1 and sets `sp_out` to SP−1. A status pop sets `psw_out` to mem[SP] and `sp_out` to SP+1.
- R7: A pair push writes `pair_in[15:8]` to SP−1 and `pair_in[7:0]` to SP−2, then sets `sp_out` to SP−2. A pair pop sets `pair_out` to {mem[SP+1], mem[SP]} and `sp_out` to SP+2.
- R8: Pair-to-SP sets `sp_out` to `pair_in`. SP-to-pair sets `pair_out` to `sp_in`. Neither touches memory.
- R9: All stack addresses and stack pointer results wrap modulo 2^16.
- R10: `start` and all operand inputs are ignored while a command is in progress. Operands are taken at the accepting edge only.
- R11: After reset, `done`, `nmi_clr`, the strobes and all four result outputs are 0. Every result a command does not change equals the corresponding input taken at start. Results are valid in the `done` cycle and hold until the next command's `done` cycle. Codes 10–15 take 2 clocks and access no memory.
- R12: At most one of `mem_we` and `mem_re` is high in any cycle, and neither is high in the `done` cycle. Read data is expected on `mem_rdata` in the cycle after `mem_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a command (taken only when idle) |
| cmd | input | 4 | Command code, see R1 |
| call_target | input | 16 | Direct call destination |
| tbl_idx | input | 5 | Table call entry offset |
| pc_in | input | 16 | Program counter of the command |
| sp_in | input | 16 | Current stack pointer |
| psw_in | input | 8 | Current status byte |
| pair_in | input | 16 | Register pair operand |
| mem_rdata | input | 8 | Read data, one cycle after `mem_re` |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 8 | Write data |
| done | output | 1 | Final clock of a command |
| pc_out | output | 16 | Resulting program counter |
| sp_out | output | 16 | Resulting stack pointer |
| psw_out | output | 8 | Resulting status byte |
| pair_out | output | 16 | Resulting register pair |
| nmi_clr | output | 1 | Clear the NMI in-service flag |

## Verification
A step counter that is off by one shows up at once as `done` arriving in the wrong cycle. It also moves a strobe into the cycle where the read data is captured, which garbles the popped byte seen in that same `done` cycle. A wrong slot plan or address choice shows as a byte written to the wrong stack location or a wrong `pc_out`, `psw_out` or `pair_out` at the end of the same command. Stale operand registers, for example a restart while busy, show as results that belong to the interfering inputs rather than the accepted ones.

// File: rtl/stkseq_pkg.sv
package stkseq_pkg;

   typedef enum logic [3:0] {
      OP_CALL      = 4'd0,
      OP_CALLT     = 4'd1,
      OP_RET       = 4'd2,
      OP_RETI      = 4'd3,
      OP_PUSH_PSW  = 4'd4,
      OP_POP_PSW   = 4'd5,
      OP_PUSH_PAIR = 4'd6,
      OP_POP_PAIR  = 4'd7,
      OP_SP_LD     = 4'd8,
      OP_SP_ST     = 4'd9
   } op_e;

   // memory access slots per command; slot k is driven in step k+1
   localparam int NSLOT = 4;
   localparam int SLOTW = $clog2(NSLOT);

   typedef enum logic [2:0] {
      A_SPM1, A_SPM2, A_SP0, A_SP1, A_SP2, A_TB0, A_TB1
   } asel_e;

   typedef enum logic [2:0] {
      D_RETH, D_RETL, D_PSW, D_PRH, D_PRL
   } dsel_e;

   typedef struct packed {
      logic  en;
      logic  wr;
      asel_e asel;
      dsel_e dsel;
   } acc_t;

   function automatic logic [3:0] op_cycles(op_e op);
      case (op)
         OP_CALL      : return 4'd6;
         OP_CALLT     : return 4'd8;
         OP_RET       : return 4'd6;
         OP_RETI      : return 4'd8;
         OP_PUSH_PSW  : return 4'd2;
         OP_POP_PSW   : return 4'd4;
         OP_PUSH_PAIR : return 4'd4;
         OP_POP_PAIR  : return 4'd6;
         OP_SP_LD     : return 4'd8;
         OP_SP_ST     : return 4'd6;
         default      : return 4'd2;
      endcase
   endfunction

   function automatic acc_t mk_acc(logic wr, asel_e a, dsel_e d);
      acc_t r;
      r.en   = 1'b1;
      r.wr   = wr;
      r.asel = a;
      r.dsel = d;
      return r;
   endfunction

   function automatic acc_t op_slot(op_e op, logic [SLOTW-1:0] slot);
      acc_t r;
      r = '{en: 1'b0, wr: 1'b0, asel: A_SP0, dsel: D_PSW};
      case (op)
         OP_CALL, OP_CALLT: begin
            if (slot == 0)      r = mk_acc(1'b1, A_SPM1, D_RETH);
            else if (slot == 1) r = mk_acc(1'b1, A_SPM2, D_RETL);
            else if (op == OP_CALLT && slot == 2) r = mk_acc(1'b0, A_TB0, D_PSW);
            else if (op == OP_CALLT && slot == 3) r = mk_acc(1'b0, A_TB1, D_PSW);
         end
         OP_RET, OP_RETI: begin
            if (slot == 0)      r = mk_acc(1'b0, A_SP0, D_PSW);
            else if (slot == 1) r = mk_acc(1'b0, A_SP1, D_PSW);
            else if (op == OP_RETI && slot == 2) r = mk_acc(1'b0, A_SP2, D_PSW);
         end
         OP_PUSH_PSW:
            if (slot == 0) r = mk_acc(1'b1, A_SPM1, D_PSW);
         OP_POP_PSW:
            if (slot == 0) r = mk_acc(1'b0, A_SP0, D_PSW);
         OP_PUSH_PAIR: begin
            if (slot == 0)      r = mk_acc(1'b1, A_SPM1, D_PRH);
            else if (slot == 1) r = mk_acc(1'b1, A_SPM2, D_PRL);
         end
         OP_POP_PAIR: begin
            if (slot == 0)      r = mk_acc(1'b0, A_SP0, D_PSW);
            else if (slot == 1) r = mk_acc(1'b0, A_SP1, D_PSW);
         end
         default: ;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/stkseq_ctrl.sv
module stkseq_ctrl
   import stkseq_pkg::*;
#(
   parameter int STEPW = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [3:0]       cmd,
   output logic [STEPW-1:0] step,
   output op_e              op_q,
   output logic             accept,
   output logic             done,
   output logic             commit
);

   localparam logic [STEPW-1:0] STEP_IDLE = '0;

   generate
      if ((2 ** STEPW) <= 8) begin : g_bad_stepw
         $error("stkseq_ctrl: STEPW too small for the longest command");
      end
   endgenerate

   logic [STEPW-1:0] n_cyc;
   logic             busy;

   assign n_cyc  = STEPW'(op_cycles(op_q));
   assign busy   = (step != STEP_IDLE);
   assign accept = start && !busy;
   assign done   = busy && (step == n_cyc);
   assign commit = busy && (step == n_cyc - STEPW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step <= STEP_IDLE;
         op_q <= OP_CALL;
      end else if (accept) begin
         step <= STEPW'(1);
         op_q <= op_e'(cmd);
      end else if (done) begin
         step <= STEP_IDLE;
      end else if (busy) begin
         step <= step + STEPW'(1);
      end
   end

endmodule

// File: rtl/stkseq_port.sv
module stkseq_port
   import stkseq_pkg::*;
#(
   parameter int             AW       = 16,
   parameter int             DW       = 8,
   parameter int             IDXW     = 5,
   parameter int             STEPW    = 4,
   parameter logic [AW-1:0]  TBL_BASE = '0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [STEPW-1:0]         step,
   input  op_e                      op_q,
   input  logic [AW-1:0]            pc_q,
   input  logic [AW-1:0]            sp_q,
   input  logic [DW-1:0]            psw_q,
   input  logic [AW-1:0]            pair_q,
   input  logic [IDXW-1:0]          idx_q,
   input  logic [DW-1:0]            mem_rdata,
   output logic [AW-1:0]            mem_addr,
   output logic                     mem_we,
   output logic                     mem_re,
   output logic [DW-1:0]            mem_wdata,
   output logic [NSLOT-1:0][DW-1:0] rbyte
);

   logic [SLOTW-1:0] slot;
   logic             in_win;
   logic             act;
   acc_t             acc;
   logic [AW-1:0]    ret_pc;
   logic [AW-1:0]    tbl_lo;
   logic [AW-1:0]    addr_c;
   logic [DW-1:0]    wd_c;

   assign in_win = (step >= STEPW'(1)) && (step <= STEPW'(NSLOT));
   assign slot   = SLOTW'(step - STEPW'(1));
   assign acc    = op_slot(op_q, slot);
   assign act    = in_win && acc.en;

   assign ret_pc = (op_q == OP_CALLT) ? pc_q + AW'(1) : pc_q + AW'(3);
   assign tbl_lo = TBL_BASE + AW'(idx_q);

   always_comb begin
      case (acc.asel)
         A_SPM1 : addr_c = sp_q - AW'(1);
         A_SPM2 : addr_c = sp_q - AW'(2);
         A_SP0  : addr_c = sp_q;
         A_SP1  : addr_c = sp_q + AW'(1);
         A_SP2  : addr_c = sp_q + AW'(2);
         A_TB0  : addr_c = tbl_lo;
         A_TB1  : addr_c = tbl_lo + AW'(1);
         default: addr_c = sp_q;
      endcase
   end

   always_comb begin
      case (acc.dsel)
         D_RETH : wd_c = ret_pc[AW-1:DW];
         D_RETL : wd_c = ret_pc[DW-1:0];
         D_PSW  : wd_c = psw_q;
         D_PRH  : wd_c = pair_q[AW-1:DW];
         D_PRL  : wd_c = pair_q[DW-1:0];
         default: wd_c = psw_q;
      endcase
   end

   assign mem_we    = act && acc.wr;
   assign mem_re    = act && !acc.wr;
   assign mem_addr  = act ? addr_c : '0;
   assign mem_wdata = mem_we ? wd_c : '0;

   // read data of slot g arrives in step g+2; one capture register per slot
   generate
      for (genvar g = 0; g < NSLOT; g++) begin : g_cap
         acc_t acc_g;
         assign acc_g = op_slot(op_q, SLOTW'(g));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               rbyte[g] <= '0;
            else if (step == STEPW'(g + 2) && acc_g.en && !acc_g.wr)
               rbyte[g] <= mem_rdata;
         end
      end
   endgenerate

endmodule

// File: rtl/stkseq_commit.sv
module stkseq_commit
   import stkseq_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     commit,
   input  op_e                      op_q,
   input  logic [AW-1:0]            pc_q,
   input  logic [AW-1:0]            sp_q,
   input  logic [DW-1:0]            psw_q,
   input  logic [AW-1:0]            pair_q,
   input  logic [AW-1:0]            tgt_q,
   input  logic [NSLOT-1:0][DW-1:0] rbyte,
   output logic [AW-1:0]            pc_out,
   output logic [AW-1:0]            sp_out,
   output logic [DW-1:0]            psw_out,
   output logic [AW-1:0]            pair_out
);

   logic [AW-1:0] n_pc, n_sp, n_pair;
   logic [DW-1:0] n_psw;

   always_comb begin
      n_pc   = pc_q;
      n_sp   = sp_q;
      n_psw  = psw_q;
      n_pair = pair_q;
      case (op_q)
         OP_CALL: begin
            n_pc = tgt_q;
            n_sp = sp_q - AW'(2);
         end
         OP_CALLT: begin
            n_pc = {rbyte[3], rbyte[2]};
            n_sp = sp_q - AW'(2);
         end
         OP_RET: begin
            n_pc = {rbyte[1], rbyte[0]};
            n_sp = sp_q + AW'(2);
         end
         OP_RETI: begin
            n_pc  = {rbyte[1], rbyte[0]};
            n_psw = rbyte[2];
            n_sp  = sp_q + AW'(3);
         end
         OP_PUSH_PSW:  n_sp = sp_q - AW'(1);
         OP_POP_PSW: begin
            n_psw = rbyte[0];
            n_sp  = sp_q + AW'(1);
         end
         OP_PUSH_PAIR: n_sp = sp_q - AW'(2);
         OP_POP_PAIR: begin
            n_pair = {rbyte[1], rbyte[0]};
            n_sp   = sp_q + AW'(2);
         end
         OP_SP_LD:     n_sp   = pair_q;
         OP_SP_ST:     n_pair = sp_q;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_out   <= '0;
         sp_out   <= '0;
         psw_out  <= '0;
         pair_out <= '0;
      end else if (commit) begin
         pc_out   <= n_pc;
         sp_out   <= n_sp;
         psw_out  <= n_psw;
         pair_out <= n_pair;
      end
   end

endmodule

// File: rtl/stk_call_seq.sv
module stk_call_seq
   import stkseq_pkg::*;
#(
   parameter int            AW       = 16,
   parameter int            DW       = 8,
   parameter int            IDXW     = 5,
   parameter logic [AW-1:0] TBL_BASE = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [3:0]      cmd,
   input  logic [AW-1:0]   call_target,
   input  logic [IDXW-1:0] tbl_idx,
   input  logic [AW-1:0]   pc_in,
   input  logic [AW-1:0]   sp_in,
   input  logic [DW-1:0]   psw_in,
   input  logic [AW-1:0]   pair_in,
   input  logic [DW-1:0]   mem_rdata,
   output logic [AW-1:0]   mem_addr,
   output logic            mem_we,
   output logic            mem_re,
   output logic [DW-1:0]   mem_wdata,
   output logic            done,
   output logic [AW-1:0]   pc_out,
   output logic [AW-1:0]   sp_out,
   output logic [DW-1:0]   psw_out,
   output logic [AW-1:0]   pair_out,
   output logic            nmi_clr
);

   localparam int STEPW = 4;

   generate
      if (AW != 2 * DW) begin : g_bad_aw
         $error("stk_call_seq: AW must be twice DW");
      end
      if (IDXW >= AW) begin : g_bad_idx
         $error("stk_call_seq: IDXW must be narrower than AW");
      end
   endgenerate

   logic [STEPW-1:0]         step;
   op_e                      op_q;
   logic                     accept;
   logic                     commit;
   logic [AW-1:0]            pc_q, sp_q, pair_q, tgt_q;
   logic [DW-1:0]            psw_q;
   logic [IDXW-1:0]          idx_q;
   logic [NSLOT-1:0][DW-1:0] rbyte;

   // operands are frozen at the accepting edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= '0;
         sp_q   <= '0;
         psw_q  <= '0;
         pair_q <= '0;
         tgt_q  <= '0;
         idx_q  <= '0;
      end else if (accept) begin
         pc_q   <= pc_in;
         sp_q   <= sp_in;
         psw_q  <= psw_in;
         pair_q <= pair_in;
         tgt_q  <= call_target;
         idx_q  <= tbl_idx;
      end
   end

   stkseq_ctrl #(.STEPW(STEPW)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .cmd    (cmd),
      .step   (step),
      .op_q   (op_q),
      .accept (accept),
      .done   (done),
      .commit (commit)
   );

   stkseq_port #(
      .AW(AW), .DW(DW), .IDXW(IDXW), .STEPW(STEPW), .TBL_BASE(TBL_BASE)
   ) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (step),
      .op_q      (op_q),
      .pc_q      (pc_q),
      .sp_q      (sp_q),
      .psw_q     (psw_q),
      .pair_q    (pair_q),
      .idx_q     (idx_q),
      .mem_rdata (mem_rdata),
      .mem_addr  (mem_addr),
      .mem_we    (mem_we),
      .mem_re    (mem_re),
      .mem_wdata (mem_wdata),
      .rbyte     (rbyte)
   );

   stkseq_commit #(.AW(AW), .DW(DW)) u_commit (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit   (commit),
      .op_q     (op_q),
      .pc_q     (pc_q),
      .sp_q     (sp_q),
      .psw_q    (psw_q),
      .pair_q   (pair_q),
      .tgt_q    (tgt_q),
      .rbyte    (rbyte),
      .pc_out   (pc_out),
      .sp_out   (sp_out),
      .psw_out  (psw_out),
      .pair_out (pair_out)
   );

   assign nmi_clr = done && (op_q == OP_RETI);

endmodule

// File: rtl/stkseq_chk.sv
module stkseq_chk #(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          done,
   input logic          nmi_clr,
   input logic          mem_we,
   input logic          mem_re,
   input logic [AW-1:0] pc_out,
   input logic [AW-1:0] sp_out,
   input logic [DW-1:0] psw_out,
   input logic [AW-1:0] pair_out
);

   a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   a_r12_quiet_final: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !(mem_we || mem_re));

   a_r5_nmi_in_done: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_clr |-> done);

   a_r11_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> ($stable(pc_out) && $stable(sp_out) &&
                $stable(psw_out) && $stable(pair_out)));

endmodule

bind stk_call_seq stkseq_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .done     (done),
   .nmi_clr  (nmi_clr),
   .mem_we   (mem_we),
   .mem_re   (mem_re),
   .pc_out   (pc_out),
   .sp_out   (sp_out),
   .psw_out  (psw_out),
   .pair_out (pair_out)
);

// File: tb/stk_call_seq_tb.sv
module stk_call_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  cmd = '0;
   logic [15:0] call_target = '0;
   logic [4:0]  tbl_idx = '0;
   logic [15:0] pc_in = '0, sp_in = '0, pair_in = '0;
   logic [7:0]  psw_in = '0;
   logic [7:0]  mem_rdata = '0;
   logic [15:0] mem_addr, pc_out, sp_out, pair_out;
   logic        mem_we, mem_re, done, nmi_clr;
   logic [7:0]  mem_wdata, psw_out;

   logic [7:0]  mem [65536];

   int errors = 0;
   int checks = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   stk_call_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
      .call_target(call_target), .tbl_idx(tbl_idx), .pc_in(pc_in),
      .sp_in(sp_in), .psw_in(psw_in), .pair_in(pair_in),
      .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
      .mem_re(mem_re), .mem_wdata(mem_wdata), .done(done),
      .pc_out(pc_out), .sp_out(sp_out), .psw_out(psw_out),
      .pair_out(pair_out), .nmi_clr(nmi_clr)
   );

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr];
   end

   task automatic chk(input string tag, input string what,
                      input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   function automatic string tag_of(input logic [3:0] c);
      case (c)
         4'd0:       return "R2";
         4'd1:       return "R3";
         4'd2:       return "R4";
         4'd3:       return "R5";
         4'd4, 4'd5: return "R6";
         4'd6, 4'd7: return "R7";
         4'd8, 4'd9: return "R8";
         default:    return "R11";
      endcase
   endfunction

   // one command; noise keeps start high with foreign operands while busy
   task automatic run(input logic [3:0] c, input logic [15:0] tg,
                      input logic [4:0] ix, input logic [15:0] pc,
                      input logic [15:0] sp, input logic [7:0] ps,
                      input logic [15:0] pr, input bit noise);
      int          n = 2;
      int          nw = 0;
      int          k;
      logic [15:0] epc = pc, esp = sp, epr = pr;
      logic [7:0]  eps = ps;
      logic        enmi = 1'b0;
      logic [15:0] ret, a0, a1, a2, m1, m2;
      logic [15:0] wa0 = '0, wa1 = '0;
      logic [7:0]  wd0 = '0, wd1 = '0, tlo, thi;
      string       tg_s = tag_of(c);
      a0 = sp; a1 = sp + 16'd1; a2 = sp + 16'd2;
      m1 = sp - 16'd1; m2 = sp - 16'd2;
      case (c)
         4'd0, 4'd1: begin
            ret = (c == 4'd0) ? pc + 16'd3 : pc + 16'd1;
            wa0 = m1; wd0 = ret[15:8]; wa1 = m2; wd1 = ret[7:0]; nw = 2;
            esp = m2;
            if (c == 4'd0) begin
               epc = tg; n = 6;
            end else begin
               tlo = (16'(ix) == wa1) ? wd1 : (16'(ix) == wa0) ? wd0 : mem[16'(ix)];
               thi = (16'(ix) + 16'd1 == wa1) ? wd1 :
                     (16'(ix) + 16'd1 == wa0) ? wd0 : mem[16'(ix) + 16'd1];
               epc = {thi, tlo}; n = 8;
            end
         end
         4'd2: begin epc = {mem[a1], mem[a0]}; esp = a2; n = 6; end
         4'd3: begin
            epc = {mem[a1], mem[a0]}; eps = mem[a2]; esp = sp + 16'd3;
            enmi = 1'b1; n = 8;
         end
         4'd4: begin wa0 = m1; wd0 = ps; nw = 1; esp = m1; n = 2; end
         4'd5: begin eps = mem[a0]; esp = a1; n = 4; end
         4'd6: begin
            wa0 = m1; wd0 = pr[15:8]; wa1 = m2; wd1 = pr[7:0]; nw = 2;
            esp = m2; n = 4;
         end
         4'd7: begin epr = {mem[a1], mem[a0]}; esp = a2; n = 6; end
         4'd8: begin esp = pr; n = 8; end
         4'd9: begin epr = sp; n = 6; end
         default: n = 2;
      endcase

      @(negedge clk);
      cmd = c; call_target = tg; tbl_idx = ix; pc_in = pc; sp_in = sp;
      psw_in = ps; pair_in = pr; start = 1'b1;
      @(negedge clk);
      if (noise) begin
         cmd = 4'd8; pair_in = ~pr; sp_in = ~sp; pc_in = ~pc;
         psw_in = ~ps; call_target = ~tg;
      end else begin
         start = 1'b0;
      end
      k = 1;
      while (!done && k < 20) begin
         @(negedge clk);
         k++;
      end
      chk(noise ? "R10" : "R1", "done cycle", 16'(k), 16'(n));
      chk("R12", "no strobe in final cycle", {14'd0, mem_we, mem_re}, 16'd0);
      chk(tg_s, "pc_out", pc_out, epc);
      chk(tg_s, "sp_out", sp_out, esp);
      chk(tg_s, "psw_out", {8'd0, psw_out}, {8'd0, eps});
      chk(tg_s, "pair_out", pair_out, epr);
      chk("R5", "nmi_clr", {15'd0, nmi_clr}, {15'd0, enmi});
      start = 1'b0;
      @(negedge clk);
      chk("R1", "done drops after one cycle", {15'd0, done}, 16'd0);
      if (nw >= 1) chk(tg_s, "first pushed byte", {8'd0, mem[wa0]}, {8'd0, wd0});
      if (nw >= 2) chk(tg_s, "second pushed byte", {8'd0, mem[wa1]}, {8'd0, wd1});
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   always @(negedge clk) begin
      if (rst_n && mem_we && mem_re) begin
         checks++;
         errors++;
         $display("FAIL R12 both strobes: got 1 expected 0");
      end
   end

   initial begin
      void'($urandom(32'd20240607));
      for (int i = 0; i < 65536; i++) mem[i] = 8'($urandom);
      repeat (3) @(negedge clk);
      chk("R11", "reset done", {15'd0, done}, 16'd0);
      chk("R11", "reset strobes", {14'd0, mem_we, mem_re}, 16'd0);
      chk("R11", "reset pc_out", pc_out, 16'd0);
      chk("R11", "reset sp_out", sp_out, 16'd0);
      chk("R11", "reset psw_out", {8'd0, psw_out}, 16'd0);
      chk("R11", "reset pair_out", pair_out, 16'd0);
      rst_n = 1'b1;

      // directed corners
      run(4'd0, 16'h4321, 5'd0, 16'h1000, 16'h0001, 8'h5A, 16'hBEEF, 0);
      chk("R9", "call wrap sp", sp_out, 16'hFFFF);
      run(4'd2, 16'h0, 5'd0, 16'h2000, 16'hFFFF, 8'h11, 16'h1234, 0);
      chk("R9", "ret wrap sp", sp_out, 16'h0001);
      run(4'd3, 16'h0, 5'd0, 16'h2000, 16'hFFFE, 8'h00, 16'h0000, 0);
      chk("R9", "reti wrap sp", sp_out, 16'h0001);
      run(4'd1, 16'h0, 5'd31, 16'h0F00, 16'hFE00, 8'h22, 16'h0, 0);
      run(4'd1, 16'h0, 5'd0, 16'hFFFF, 16'h8000, 8'h22, 16'h0, 0);
      run(4'd4, 16'h0, 5'd0, 16'h0, 16'h0000, 8'hA5, 16'h0, 0);
      run(4'd5, 16'h0, 5'd0, 16'h0, 16'hFFFF, 8'h3C, 16'h0, 0);
      run(4'd6, 16'h0, 5'd0, 16'h0, 16'h0001, 8'h00, 16'hCAFE, 0);
      run(4'd7, 16'h0, 5'd0, 16'h0, 16'hFFFF, 8'h00, 16'h0, 0);
      run(4'd8, 16'h0, 5'd0, 16'h0, 16'h1111, 8'h00, 16'h7777, 0);
      run(4'd9, 16'h0, 5'd0, 16'h0, 16'h2468, 8'h00, 16'h9999, 0);
      run(4'd15, 16'h0, 5'd0, 16'hABCD, 16'h1357, 8'h99, 16'h8642, 0);
      run(4'd3, 16'h0, 5'd0, 16'h1234, 16'h4000, 8'h77, 16'h5555, 1);
      run(4'd4, 16'h0, 5'd0, 16'h1234, 16'h4000, 8'h77, 16'h5555, 1);

      // constrained random mix
      for (int t = 0; t < 300; t++) begin
         logic [3:0] c;
         c = ($urandom % 8 == 0) ? 4'(10 + $urandom % 6) : 4'($urandom % 10);
         run(c, 16'($urandom), 5'($urandom), 16'($urandom), 16'($urandom),
             8'($urandom), 16'($urandom), ($urandom % 6) == 0);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule